// File: doc/BRIEF.md
# Automatic Serial Flow Controller

This block decides when one serial channel may send and when the far end must stop sending. For hardware handshaking it watches the receive buffer fill level. It drops the ready-to-receive output once the level reaches a programmable halt mark. It raises that output again only after the level has drained to a lower resume mark, so the output does not chatter between the two marks. It also gates the local transmitter with the incoming clear-to-send line. A character that is already leaving the transmitter is always allowed to finish.

For in-band handshaking it compares every received character with two programmable codes, one that resumes sending and one that pauses it. Matched codes are swallowed and are not stored in the receive buffer. An option lets any received character resume a paused transmitter. In the other direction, the block asks the transmitter to insert a pause code when the receive level reaches the halt mark. It asks for a resume code only after the level has drained to the resume mark. Each request stays up until the transmitter acknowledges it.

The two marks are 4-bit fields, and each step is four buffer entries. The framing logic, the buffers and the baud generator sit outside this block.

Top module: `flow_ctrl_top`

## Requirements
- R1: After a synchronous reset, `rts` is 1, `tx_enable` is 1, `flow_req` is 0 and `rx_store` is 0.
- R2: With `cfg_auto_rts`=1, `rts` is 0 on the clock edge after a cycle in which `rx_level` >= 4*`cfg_halt_thr`.
- R3: With `cfg_auto_rts`=1, `rts` returns to 1 only on the edge after a cycle in which `rx_level` <= 4*`cfg_resume_thr`. Between the two marks `rts` keeps its previous value. The halt mark wins if both marks hold at once.
- R4: With `cfg_auto_rts`=0, `rts` stays 1 at every fill level.
- R5: With `cfg_auto_cts`=1 and no character in progress, `cts`=0 makes `tx_enable` 0 on the next edge, and `cts`=1 makes it 1 again. With `cfg_auto_cts`=0, `cts` has no effect on `tx_enable`.
- R6: While `tx_busy`=1 and `tx_enable` is 1, `tx_enable` stays 1, whatever `cts` or the pause state is.
- R7: With `cfg_sw_rx_en`=1, a received character equal to `cfg_xoff_char` makes `tx_enable` 0 two edges after the `rx_valid` cycle. A received `cfg_xon_char` makes it 1 again with the same latency.
- R8: With `cfg_xany`=1, any received character resumes a paused transmitter. With `cfg_xany`=0, a character that matches neither code leaves the transmitter paused.
- R9: `rx_store` is 1 on the edge after a `rx_valid` cycle, unless `cfg_sw_rx_en`=1 and the character matches either code. With `cfg_sw_rx_en`=0, every character is stored.
- R10: With `cfg_sw_tx_en`=1, the edge after a cycle in which `rx_level` >= 4*`cfg_halt_thr` raises `flow_req` with `flow_char`=`cfg_xoff_char`. The request and the character hold until a `flow_ack` cycle, after which `flow_req` is 0.
- R11: After a pause code is acknowledged, no new pause request is made. A resume request (`flow_char`=`cfg_xon_char`) is raised only after a cycle with `rx_level` <= 4*`cfg_resume_thr`. No resume request is made before any pause code has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_auto_rts | input | 1 | Drive `rts` from fill level |
| cfg_auto_cts | input | 1 | Gate transmitter with `cts` |
| cfg_sw_rx_en | input | 1 | Act on received pause/resume codes |
| cfg_sw_tx_en | input | 1 | Request pause/resume code insertion |
| cfg_xany | input | 1 | Any received character resumes |
| cfg_halt_thr | input | 4 | Halt mark, units of 4 entries |
| cfg_resume_thr | input | 4 | Resume mark, units of 4 entries |
| cfg_xon_char | input | 8 | Resume code |
| cfg_xoff_char | input | 8 | Pause code |
| rx_level | input | 7 | Receive buffer fill level |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| cts | input | 1 | Clear to send from far end, 1 = may send |
| tx_busy | input | 1 | Transmitter is shifting a character |
| flow_ack | input | 1 | Transmitter accepted the inserted code |
| rts | output | 1 | Ready to receive, 1 = far end may send |
| tx_enable | output | 1 | Transmitter may start or continue |
| rx_store | output | 1 | Write the last received character to the buffer |
| flow_req | output | 1 | Request to insert a flow code |
| flow_char | output | 8 | Code to insert |

## Verification
A wrong hysteresis state shows at `rts` on the first level step that crosses a mark. The state is visible one edge later, so a level sweep up and back down across each pair of marks exposes it. A wrong pause flag shows at `tx_enable` two edges after the offending character. A wrong record of which code was sent last shows at once at `flow_req`. The symptom is either a repeated pause request while the level is still high, or a resume request that appears before any pause code was sent.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic {FC_RESUME = 1'b0, FC_PAUSE = 1'b1} fc_kind_e;

  function automatic int unsigned mark_level(input int unsigned thr, input int unsigned unit_shift);
    return thr << unit_shift;
  endfunction
endpackage

// File: rtl/fc_rts_ctl.sv
module fc_rts_ctl #(
  parameter int LEVEL_W = 7,
  parameter int THR_W = 4,
  parameter int UNIT_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               auto_rts,
  input  logic [THR_W-1:0]   halt_thr,
  input  logic [THR_W-1:0]   resume_thr,
  input  logic [LEVEL_W-1:0] level,
  output logic               rts
);
  localparam int CMP_W = LEVEL_W + 1;

  logic [CMP_W-1:0] halt_lvl, resume_lvl;
  logic             halted_q, halted_d;

  assign halt_lvl   = CMP_W'(fc_pkg::mark_level(halt_thr, UNIT_SHIFT));
  assign resume_lvl = CMP_W'(fc_pkg::mark_level(resume_thr, UNIT_SHIFT));

  always_comb begin
    halted_d = halted_q;
    if (CMP_W'(level) >= halt_lvl)        halted_d = 1'b1;
    else if (CMP_W'(level) <= resume_lvl) halted_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      rts      <= 1'b1;
    end else begin
      halted_q <= halted_d;
      rts      <= !(auto_rts && halted_d);
    end
  end

  p_rts_halt_r2: assert property (@(posedge clk) disable iff (rst)
    (auto_rts && CMP_W'(level) >= halt_lvl) |=> !rts);
  p_rts_resume_r3: assert property (@(posedge clk) disable iff (rst)
    (CMP_W'(level) <= resume_lvl && CMP_W'(level) < halt_lvl) |=> rts);
  p_rts_off_r4: assert property (@(posedge clk) disable iff (rst)
    !auto_rts |=> rts);
endmodule

// File: rtl/fc_rx_filter.sv
module fc_rx_filter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rx_en,
  input  logic              xany,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              paused,
  output logic              rx_store
);
  logic is_off, is_on;
  assign is_off = sw_rx_en && (rx_char == xoff_char);
  assign is_on  = sw_rx_en && (rx_char == xon_char);

  always_ff @(posedge clk) begin
    if (rst) begin
      paused   <= 1'b0;
      rx_store <= 1'b0;
    end else begin
      rx_store <= rx_valid && !(is_off || is_on);
      if (!sw_rx_en)                  paused <= 1'b0;
      else if (rx_valid) begin
        if (is_off)                   paused <= 1'b1;
        else if (is_on || xany)       paused <= 1'b0;
      end
    end
  end

  p_consume_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (is_off || is_on)) |=> !rx_store);
  p_pause_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && is_off) |=> paused);
  p_noany_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_rx_en && paused && !xany && !(rx_valid && is_on)) |=> paused);
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic auto_cts,
  input  logic cts,
  input  logic tx_busy,
  input  logic sw_paused,
  output logic tx_enable
);
  logic allow;
  assign allow = !(auto_cts && !cts) && !sw_paused;

  always_ff @(posedge clk) begin
    if (rst)                        tx_enable <= 1'b1;
    else if (tx_busy && tx_enable)  tx_enable <= 1'b1;
    else                            tx_enable <= allow;
  end

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && tx_enable) |=> tx_enable);
  p_cts_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (auto_cts && !cts && !tx_busy) |=> !tx_enable);
endmodule

// File: rtl/fc_flow_tx.sv
module fc_flow_tx #(
  parameter int LEVEL_W = 7,
  parameter int THR_W = 4,
  parameter int UNIT_SHIFT = 2,
  parameter int CHAR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_tx_en,
  input  logic [THR_W-1:0]   halt_thr,
  input  logic [THR_W-1:0]   resume_thr,
  input  logic [LEVEL_W-1:0] level,
  input  logic [CHAR_W-1:0]  xon_char,
  input  logic [CHAR_W-1:0]  xoff_char,
  input  logic               ack,
  output logic               flow_req,
  output logic [CHAR_W-1:0]  flow_char
);
  import fc_pkg::*;
  localparam int CMP_W = LEVEL_W + 1;

  logic [CMP_W-1:0] halt_lvl, resume_lvl;
  logic             sent_off;
  fc_kind_e         kind_q;
  logic             need_off, need_on;

  assign halt_lvl   = CMP_W'(mark_level(halt_thr, UNIT_SHIFT));
  assign resume_lvl = CMP_W'(mark_level(resume_thr, UNIT_SHIFT));
  assign need_off   = !sent_off && CMP_W'(level) >= halt_lvl;
  assign need_on    = sent_off && CMP_W'(level) <= resume_lvl;

  always_ff @(posedge clk) begin
    if (rst || !sw_tx_en) begin
      flow_req  <= 1'b0;
      sent_off  <= 1'b0;
      kind_q    <= FC_RESUME;
      flow_char <= '0;
    end else if (flow_req && ack) begin
      flow_req <= 1'b0;
      sent_off <= (kind_q == FC_PAUSE);
    end else if (!flow_req && (need_off || need_on)) begin
      flow_req  <= 1'b1;
      kind_q    <= need_off ? FC_PAUSE : FC_RESUME;
      flow_char <= need_off ? xoff_char : xon_char;
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (sw_tx_en && flow_req && !ack) |=> (flow_req && $stable(flow_char)));
  p_ack_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (flow_req && ack) |=> !flow_req);
  p_no_early_on_r11: assert property (@(posedge clk) disable iff (rst)
    (!sent_off && !need_off && !flow_req) |=> !flow_req);
endmodule

// File: rtl/flow_ctrl_top.sv
module flow_ctrl_top #(
  parameter int LEVEL_W = 7,
  parameter int THR_W = 4,
  parameter int THR_UNIT = 4,
  parameter int CHAR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_auto_rts,
  input  logic               cfg_auto_cts,
  input  logic               cfg_sw_rx_en,
  input  logic               cfg_sw_tx_en,
  input  logic               cfg_xany,
  input  logic [THR_W-1:0]   cfg_halt_thr,
  input  logic [THR_W-1:0]   cfg_resume_thr,
  input  logic [CHAR_W-1:0]  cfg_xon_char,
  input  logic [CHAR_W-1:0]  cfg_xoff_char,
  input  logic [LEVEL_W-1:0] rx_level,
  input  logic               rx_valid,
  input  logic [CHAR_W-1:0]  rx_char,
  input  logic               cts,
  input  logic               tx_busy,
  input  logic               flow_ack,
  output logic               rts,
  output logic               tx_enable,
  output logic               rx_store,
  output logic               flow_req,
  output logic [CHAR_W-1:0]  flow_char
);
  localparam int UNIT_SHIFT = $clog2(THR_UNIT);

  logic sw_paused;

  fc_rts_ctl #(.LEVEL_W(LEVEL_W), .THR_W(THR_W), .UNIT_SHIFT(UNIT_SHIFT)) u_rts (
    .clk(clk), .rst(rst), .auto_rts(cfg_auto_rts), .halt_thr(cfg_halt_thr),
    .resume_thr(cfg_resume_thr), .level(rx_level), .rts(rts));

  fc_rx_filter #(.CHAR_W(CHAR_W)) u_rxf (
    .clk(clk), .rst(rst), .sw_rx_en(cfg_sw_rx_en), .xany(cfg_xany),
    .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char), .rx_valid(rx_valid),
    .rx_char(rx_char), .paused(sw_paused), .rx_store(rx_store));

  fc_tx_gate u_gate (
    .clk(clk), .rst(rst), .auto_cts(cfg_auto_cts), .cts(cts), .tx_busy(tx_busy),
    .sw_paused(sw_paused), .tx_enable(tx_enable));

  fc_flow_tx #(.LEVEL_W(LEVEL_W), .THR_W(THR_W), .UNIT_SHIFT(UNIT_SHIFT), .CHAR_W(CHAR_W)) u_ftx (
    .clk(clk), .rst(rst), .sw_tx_en(cfg_sw_tx_en), .halt_thr(cfg_halt_thr),
    .resume_thr(cfg_resume_thr), .level(rx_level), .xon_char(cfg_xon_char),
    .xoff_char(cfg_xoff_char), .ack(flow_ack), .flow_req(flow_req), .flow_char(flow_char));

  p_paused_stops_r7: assert property (@(posedge clk) disable iff (rst)
    (sw_paused && !tx_busy) |=> !tx_enable);
endmodule

// File: tb/flow_ctrl_top_tb.sv
module flow_ctrl_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic auto_rts = 0, auto_cts = 0, sw_rx = 0, sw_tx = 0, xany = 0;
  logic [3:0] halt_thr = 4'd8, resume_thr = 4'd2;
  logic [7:0] xon = 8'h11, xoff = 8'h13;
  logic [6:0] level = '0;
  logic rx_valid = 0; logic [7:0] rx_char = '0;
  logic cts = 1, tx_busy = 0, ack = 0;
  logic rts, tx_enable, rx_store, flow_req; logic [7:0] flow_char;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_ctrl_top u_dut (
    .clk(clk), .rst(rst), .cfg_auto_rts(auto_rts), .cfg_auto_cts(auto_cts),
    .cfg_sw_rx_en(sw_rx), .cfg_sw_tx_en(sw_tx), .cfg_xany(xany),
    .cfg_halt_thr(halt_thr), .cfg_resume_thr(resume_thr), .cfg_xon_char(xon),
    .cfg_xoff_char(xoff), .rx_level(level), .rx_valid(rx_valid), .rx_char(rx_char),
    .cts(cts), .tx_busy(tx_busy), .flow_ack(ack), .rts(rts), .tx_enable(tx_enable),
    .rx_store(rx_store), .flow_req(flow_req), .flow_char(flow_char));

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    rx_valid = 1; rx_char = c; step(); rx_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit halted;
    int hs[3] = '{2, 8, 15};
    repeat (3) step();
    chk(rts == 1 && tx_enable == 1 && flow_req == 0 && rx_store == 0, "R1", {rts, tx_enable, flow_req, rx_store}, 4'b1100);
    rst = 0; step();

    // R4: auto-RTS off, level sweep
    for (int l = 0; l <= 64; l += 8) begin
      level = 7'(l); step();
      chk(rts == 1, "R4", rts, 1);
    end

    // R2/R3: hysteresis sweeps
    auto_rts = 1;
    foreach (hs[i]) begin
      for (int r = 0; r < 3; r++) begin
        int rv = (r == 2) ? hs[i] - 1 : r;
        halt_thr = 4'(hs[i]); resume_thr = 4'(rv);
        level = 0; step(); halted = 0;
        for (int l = 0; l <= 64; l++) begin
          level = 7'(l); step();
          if (l >= 4*hs[i]) halted = 1; else if (l <= 4*rv) halted = 0;
          chk(rts == !halted, "R2", rts, !halted);
        end
        for (int l = 64; l >= 0; l--) begin
          level = 7'(l); step();
          if (l >= 4*hs[i]) halted = 1; else if (l <= 4*rv) halted = 0;
          chk(rts == !halted, "R3", rts, !halted);
        end
      end
    end
    auto_rts = 0; level = 0; halt_thr = 4'd8; resume_thr = 4'd2; step();

    // R5: CTS gating
    cts = 0; step();
    chk(tx_enable == 1, "R5 off", tx_enable, 1);
    auto_cts = 1; step();
    chk(tx_enable == 0, "R5", tx_enable, 0);
    cts = 1; step();
    chk(tx_enable == 1, "R5", tx_enable, 1);
    // R6: character in progress
    tx_busy = 1; step(); cts = 0; step();
    chk(tx_enable == 1, "R6", tx_enable, 1);
    step();
    chk(tx_enable == 1, "R6", tx_enable, 1);
    tx_busy = 0; step();
    chk(tx_enable == 0, "R6 end", tx_enable, 0);
    cts = 1; auto_cts = 0; step();

    // R9: storing with in-band handling off
    send(xoff);
    chk(rx_store == 1, "R9", rx_store, 1);
    step();
    chk(tx_enable == 1, "R9 ignored", tx_enable, 1);
    sw_rx = 1;
    send(8'h41);
    chk(rx_store == 1, "R9", rx_store, 1);
    // R7 / R8
    send(xoff);
    chk(rx_store == 0, "R9", rx_store, 0);
    step();
    chk(tx_enable == 0, "R7", tx_enable, 0);
    send(8'h42); step();
    chk(tx_enable == 0, "R8", tx_enable, 0);
    send(xon);
    chk(rx_store == 0, "R9", rx_store, 0);
    step();
    chk(tx_enable == 1, "R7", tx_enable, 1);
    send(xoff); step();
    chk(tx_enable == 0, "R7", tx_enable, 0);
    xany = 1;
    send(8'h43);
    chk(rx_store == 1, "R8", rx_store, 1);
    step();
    chk(tx_enable == 1, "R8", tx_enable, 1);
    // R6 with pause
    tx_busy = 1; step(); send(xoff); step();
    chk(tx_enable == 1, "R6", tx_enable, 1);
    tx_busy = 0; step();
    chk(tx_enable == 0, "R6 end", tx_enable, 0);
    send(xon); step(); sw_rx = 0; xany = 0;

    // R10 / R11: code insertion
    sw_tx = 1; level = 0; step(); step();
    chk(flow_req == 0, "R11 none", flow_req, 0);
    level = 7'd32; step();
    chk(flow_req == 1 && flow_char == xoff, "R10", flow_char, xoff);
    repeat (3) step();
    chk(flow_req == 1 && flow_char == xoff, "R10 hold", flow_req, 1);
    ack = 1; step(); ack = 0;
    chk(flow_req == 0, "R10", flow_req, 0);
    repeat (3) step();
    chk(flow_req == 0, "R11", flow_req, 0);
    level = 7'd9; step(); step();
    chk(flow_req == 0, "R11 mid", flow_req, 0);
    level = 7'd8; step();
    chk(flow_req == 1 && flow_char == xon, "R11", flow_char, xon);
    ack = 1; step(); ack = 0;
    chk(flow_req == 0, "R11", flow_req, 0);
    step();
    chk(flow_req == 0, "R11", flow_req, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule